// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital front end of a 12-bit DAC that takes its settings over a three-wire serial port. The port has three wires: an active-low frame select, a serial clock and a data line. A frame is 16 bits long and arrives most significant bit first. Each bit is taken on a falling edge of the serial clock. When a whole frame has arrived, the block loads a held 12-bit output code and a 2-bit power-down mode from that frame, and it raises an update strobe for one system clock.

The three pins are not in the system clock domain. Each pin passes through its own synchronizer chain into a system clock that runs at least four times faster than the serial clock, and edges are detected after the synchronizers. A frame is thrown away if the select line rises before its last bit. Clock edges that come after a complete frame are ignored until the select line goes high and then low again. Downstream analog logic reads only the code and the mode.

Top module: `dac_serial_rx`

## Requirements
- R1: Serial clock falling edges have no effect while the synchronized select is high. A frame is open only while select stays low.
- R2: On the 16th falling edge of a frame, code_o takes frame bits 11..0. The first bit shifted in is frame bit 15.
- R3: If select rises after fewer than 16 falling edges, code_o and mode_o keep their previous values and upd_o stays low.
- R4: On a complete frame, mode_o takes frame bits 13..12. The encoding is 00 normal output, 01 power-down with 1 kΩ to ground, 10 power-down with 100 kΩ to ground, and 11 power-down with high-impedance output.
- R5: upd_o is high for exactly one system clock per complete frame. code_o and mode_o change only in that cycle.
- R6: Falling edges after the 16th in the same frame change nothing. For example, 20 edges carrying 0x1234 followed by ones leave code 0x234 and mode 01.
- R7: While reset is asserted and after it is released, code_o is 0, mode_o is 00 and upd_o is 0.
- R8: Frame bits 15..14 are ignored. A frame of 0xC123 gives code 0x123 and mode 00.
- R9: The outputs change on the (SYNC_STAGES+1)th system clock rising edge after the pin-level 16th falling edge.
- R10: Frames are received correctly when the serial clock half-period is only two system clocks, which is a 4:1 clock ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_ni | input | 1 | Active-low frame select pin |
| sck_i | input | 1 | Serial clock pin |
| sdi_i | input | 1 | Serial data pin |
| code_o | output | CODE_W | Held output code |
| mode_o | output | MODE_W | Held power-down mode |
| upd_o | output | 1 | One-cycle update strobe |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 16-bit frame, a 12-bit code and a 2-bit mode. With two stages, the bench's reference model can place every update strobe on an exact cycle, three clocks after the pin edge. The 16-bit frame also puts the abort boundary, a 15-bit frame, and the extra-clock case within a few hundred cycles. The serial clock half-period is a parameter of the bench's drive task. Running it at 4 and at 2 system clocks covers both the relaxed 8:1 ratio and the minimum 4:1 ratio.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;
  typedef enum logic [1:0] {
    PD_NORMAL = 2'b00,
    PD_1K     = 2'b01,
    PD_100K   = 2'b10,
    PD_HIZ    = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int unsigned        STAGES  = 2,
  parameter int unsigned        WIDTH   = 3,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else if (STAGES == 1) chain_q <= d_i[b];
      else chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/dac_rx_edge.sv
module dac_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic sel_s_ni,
  output logic sck_fall_o,
  output logic sel_low_o
);
  logic sck_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else sck_prev_q <= sck_s_i;
  end

  assign sck_fall_o = sck_prev_q & ~sck_s_i;
  assign sel_low_o  = ~sel_s_ni;
endmodule

// File: rtl/dac_rx_frame.sv
module dac_rx_frame #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned DATA_BITS  = 14,
  parameter int unsigned CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_low_i,
  input  logic                 sck_fall_i,
  input  logic                 sdi_i,
  output logic                 word_vld_o,
  output logic [DATA_BITS-1:0] word_o,
  output logic [CNT_W-1:0]     bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

  // only the low DATA_BITS-1 bits are kept; upper frame bits fall off the end
  logic [DATA_BITS-2:0] shreg_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 take;

  assign take = sel_low_i & sck_fall_i & (cnt_q != FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (!sel_low_i) begin
      cnt_q <= '0;
    end else if (take) begin
      shreg_q <= {shreg_q[DATA_BITS-3:0], sdi_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign word_vld_o = take & (cnt_q == LAST);
  assign word_o     = {shreg_q, sdi_i};
  assign bit_cnt_o  = cnt_q;
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx
  import dac_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FRAME_BITS  = 16,
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned MODE_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              upd_o
);
  localparam int unsigned DATA_BITS = CODE_W + MODE_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_BITS + 1);
  localparam logic [MODE_W-1:0] MODE_RST = MODE_W'(PD_NORMAL);

  logic [2:0]           pins_s;
  logic                 sck_fall, sel_low, word_vld;
  logic [DATA_BITS-1:0] word;
  logic [CNT_W-1:0]     bit_cnt;
  logic [CODE_W-1:0]    code_q;
  logic [MODE_W-1:0]    mode_q;
  logic                 upd_q;

  // pin order {sel, sck, sdi}; select idles high
  dac_rx_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_ni, sck_i, sdi_i}),
    .q_o   (pins_s)
  );

  dac_rx_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (pins_s[1]),
    .sel_s_ni  (pins_s[2]),
    .sck_fall_o(sck_fall),
    .sel_low_o (sel_low)
  );

  dac_rx_frame #(
    .FRAME_BITS(FRAME_BITS),
    .DATA_BITS (DATA_BITS),
    .CNT_W     (CNT_W)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_low_i (sel_low),
    .sck_fall_i(sck_fall),
    .sdi_i     (pins_s[0]),
    .word_vld_o(word_vld),
    .word_o    (word),
    .bit_cnt_o (bit_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mode_q <= MODE_RST;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= word_vld;
      if (word_vld) begin
        code_q <= word[CODE_W-1:0];
        mode_q <= word[DATA_BITS-1:CODE_W];
      end
    end
  end

  assign code_o = code_q;
  assign mode_o = mode_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/dac_serial_rx_chk.sv
module dac_serial_rx_chk #(
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned MODE_W     = 2,
  parameter int unsigned CNT_W      = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_low_i,
  input logic [CNT_W-1:0]  bit_cnt_i,
  input logic [CODE_W-1:0] code_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              upd_o
);
  p_upd_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  p_code_moves_on_upd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_o) |-> upd_o);

  p_mode_moves_on_upd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_o) |-> upd_o);

  p_upd_inside_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(sel_low_i));

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= CNT_W'(FRAME_BITS));

  p_cnt_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sel_low_i) |-> bit_cnt_i == '0);
endmodule

bind dac_serial_rx dac_serial_rx_chk #(
  .FRAME_BITS(FRAME_BITS),
  .CODE_W    (CODE_W),
  .MODE_W    (MODE_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_low_i(sel_low),
  .bit_cnt_i(bit_cnt),
  .code_o   (code_o),
  .mode_o   (mode_o),
  .upd_o    (upd_o)
);

// File: tb/dac_serial_rx_tb.sv
module dac_serial_rx_tb;
  localparam int SYNC_STAGES = 2;
  localparam int LAT = SYNC_STAGES + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [11:0] code;
  logic [1:0]  mode;
  logic        upd;

  always #4 clk = ~clk;

  dac_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_dut (
    .clk_i (clk),
    .rst_ni(rst_n),
    .sel_ni(sel_n),
    .sck_i (sck),
    .sdi_i (sdi),
    .code_o(code),
    .mode_o(mode),
    .upd_o (upd)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  bit finished = 0;
  bit pend = 0;
  int pend_cyc = 0;
  logic [11:0] pend_code, m_code = '0;
  logic [1:0]  pend_mode, m_mode = '0;
  int exp_pulses = 0, seen_pulses = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // cycle-by-cycle reference model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_upd;
      exp_upd = 1'b0;
      if (pend && cyc == pend_cyc) begin
        m_code = pend_code;
        m_mode = pend_mode;
        exp_upd = 1'b1;
        pend = 0;
      end
      if (upd) seen_pulses++;
      check(code === m_code, "R2 code", int'(code), int'(m_code));
      check(mode === m_mode, "R4 mode", int'(mode), int'(m_mode));
      check(upd === exp_upd, "R5 R9 strobe", int'(upd), int'(exp_upd));
    end
  end

  task automatic send(input logic [15:0] w, input int nbits, input int half);
    @(negedge clk) sel_n = 1'b0;
    repeat (2 * half) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b1;
      sck = 1'b1;
      repeat (half) @(negedge clk);
      sck = 1'b0;
      if (i == 15) begin
        pend = 1;
        pend_cyc = cyc + LAT;
        pend_code = w[11:0];
        pend_mode = w[13:12];
        exp_pulses++;
      end
      repeat (half) @(negedge clk);
    end
    sel_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic expect_out(input logic [11:0] c, input logic [1:0] m, input string tag);
    check(code === c, tag, int'(code), int'(c));
    check(mode === m, tag, int'(mode), int'(m));
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(code === 12'h000 && mode === 2'b00 && upd === 1'b0, "R7 in reset",
          int'({code, mode, upd}), 0);
    repeat (2) @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_out(12'h000, 2'b00, "R7 after reset");

    // R1: clock activity with select high
    for (int i = 0; i < 20; i++) begin
      sdi = i[0];
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    expect_out(12'h000, 2'b00, "R1 select high");

    send(16'h0ABC, 16, 4); expect_out(12'hABC, 2'b00, "R2 normal");
    send(16'h1FFF, 16, 4); expect_out(12'hFFF, 2'b01, "R4 1k");
    send(16'h2000, 16, 4); expect_out(12'h000, 2'b10, "R4 100k");
    send(16'h3555, 16, 4); expect_out(12'h555, 2'b11, "R4 hiz");
    send(16'hC123, 16, 4); expect_out(12'h123, 2'b00, "R8 top bits");

    // R3: aborted frames, including one bit short
    send(16'h3FFF, 10, 4); expect_out(12'h123, 2'b00, "R3 abort 10");
    send(16'h2E0F, 15, 4); expect_out(12'h123, 2'b00, "R3 abort 15");

    // R6: extra clocks after the 16th bit
    send(16'h1234, 20, 4); expect_out(12'h234, 2'b01, "R6 extra clocks");

    // R10: 4:1 clock ratio
    send(16'h2A5A, 16, 2); expect_out(12'hA5A, 2'b10, "R10 fast");
    send(16'h0001, 18, 2); expect_out(12'h001, 2'b00, "R10 R6 fast extra");

    repeat (10) @(negedge clk);
    check(seen_pulses == exp_pulses, "R5 pulse count", seen_pulses, exp_pulses);
    finish_run();
  end
endmodule